// File: doc/BRIEF.md
# ATA PIO Device Register Interface

This block is the device end of a parallel ATA host port running programmed I/O in true IDE mode. The host's asynchronous read and write strobes, its two active-low chip selects, its 3-bit register address and its 16-bit data bus are brought into a fast internal clock domain. In that domain the block decodes register accesses and holds the task-file registers. It hands command bytes and data-port words to an internal execution core and returns status, error and data words from that core to the host.

Reads and writes to the eight-bit registers use only the low byte of the bus. Data-port accesses use the full word, and the block signals them on an active-low width indicator. When the core cannot yet supply or accept a data-port word, the ready output is pulled low so that the host extends its strobe. The interrupt request is set by the core. It is withdrawn by a Status read, by a Command write or by a software reset. Its output driver is switched off while the host has interrupts disabled.

A configuration pin chooses whether the device answers as device 0 or device 1. Reads, command writes and data-port transfers are honoured only when the drive-select bit of the device register matches that choice. Ordinary task-file writes are always taken, as both devices on a cable must latch them.

Top module: `ata_pio_devif`

## Requirements
- R1: With chip select 0 low and chip select 1 high, address 1 reads the core error byte and writes the feature byte, and addresses 2 to 6 are sector count, LBA bits 7:0, LBA bits 15:8, LBA bits 23:16 and device register. Each of those five registers reads back the value last written on bits 7:0. Reading address 1 never shows the feature byte.
- R2: A register write takes effect only after the write strobe returns high, and it uses the data held during the strobe. Bits 15:8 of a register write are ignored.
- R3: The data bus output enable is raised only while a read strobe is low, and it drops within two clocks after the strobe rises.
- R4: Ready goes low during a selected data-port (address 0) read while the core has no word available, and during a selected data-port write while the core has no room. It returns high once the condition clears. It stays high for register accesses.
- R5: The 16-bit indicator is low only during a selected data-port access. On register reads bits 15:8 of the bus are zero. Data-port reads return the full 16-bit core word.
- R6: A read of address 7 (Status, chip select 0) returns the core status byte and clears a pending interrupt.
- R7: A read of address 6 with chip select 1 low and chip select 0 high (alternate status) returns the same status byte and leaves the interrupt pending.
- R8: A write to address 7 (Command) emits a one-clock command strobe carrying the written byte and clears a pending interrupt.
- R9: When an interrupt set from the core and a Status-read or Command-write clear fall in the same clock, the interrupt ends up pending.
- R10: Device control (write to address 6 with chip select 1) bit 1 set switches the interrupt output enable off. Clearing the bit switches it back on.
- R11: Device control bit 2 set clears a pending interrupt, blocks new interrupt sets, and forces status bit 7 (busy) to one while it stays set.
- R12: When device register bit 4 differs from the configuration input (0 = device 0, 1 = device 1), reads leave the bus undriven and command and data-port writes are dropped. Writes to the task-file registers are still accepted.
- R13: The end of a selected data-port read strobe gives one take pulse to the core. The end of a selected data-port write strobe gives one strobe with the 16-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_slave | input | 1 | Role select: 0 device 0, 1 device 1 |
| hst_cs0_n | input | 1 | Host chip select for command-block registers, active low |
| hst_cs1_n | input | 1 | Host chip select for control-block registers, active low |
| hst_addr | input | 3 | Host register address |
| hst_rd_n | input | 1 | Host read strobe, active low |
| hst_wr_n | input | 1 | Host write strobe, active low |
| hst_data_i | input | DW | Host data bus, inbound |
| hst_data_o | output | DW | Host data bus, outbound |
| hst_data_oe | output | 1 | Output enable for the host data bus |
| hst_rdy | output | 1 | Cycle ready; low extends the host strobe |
| hst_w16_n | output | 1 | Low during word-wide data-port cycles |
| hst_irq | output | 1 | Interrupt request level |
| hst_irq_oe | output | 1 | Output enable for the interrupt pad |
| core_stat | input | 8 | Status byte from the core |
| core_err | input | 8 | Error byte from the core |
| core_irq_set | input | 1 | One-clock interrupt request from the core |
| cmd_stb | output | 1 | One-clock pulse on a Command write |
| cmd_code | output | 8 | Command byte |
| tf_regs | output | 48 | Task file {device, lba 23:16, lba 15:8, lba 7:0, count, feature} |
| dp_rd_word | input | DW | Next data word from the core |
| dp_rd_avail | input | 1 | Core has a word for the host |
| dp_rd_take | output | 1 | Host has consumed the word |
| dp_wr_word | output | DW | Word written by the host |
| dp_wr_stb | output | 1 | One-clock pulse with a host data word |
| dp_wr_room | input | 1 | Core can accept a data word |

## Verification
The interrupt flag can be set from the core and cleared by the end of a Status read in the same clock. The bench finishes a Status read with no interrupt pending. It counts the synchroniser stages after the strobe rises and pulses the core's set request in the exact clock in which the clear edge is registered. The interrupt must then be seen pending. A plain Status read before and after this must clear it, which shows that the clear path works and that the set path has priority.

// File: rtl/ata_devif_pkg.sv
package ata_devif_pkg;

    localparam int ADDR_W   = 3;
    localparam int BYTE_W   = 8;
    localparam int DEV_BIT  = 4;   // drive-select bit in device register
    localparam int NIEN_BIT = 1;   // interrupt disable in device control
    localparam int SRST_BIT = 2;   // software reset in device control
    localparam int BSY_BIT  = 7;   // busy flag in status

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_ERRFEAT,
        SEL_COUNT,
        SEL_LBA0,
        SEL_LBA1,
        SEL_LBA2,
        SEL_DEVICE,
        SEL_STATCMD,
        SEL_ALTCTL
    } regsel_e;

    typedef struct packed {
        logic [BYTE_W-1:0] device;
        logic [BYTE_W-1:0] lba2;
        logic [BYTE_W-1:0] lba1;
        logic [BYTE_W-1:0] lba0;
        logic [BYTE_W-1:0] count;
        logic [BYTE_W-1:0] feat;
    } taskfile_t;

endpackage

// File: rtl/ata_sync_chain.sv
module ata_sync_chain #(
    parameter int            W       = 8,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] chain_d [STAGES];
    logic [W-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= chain_d[i];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/ata_reg_decode.sv
module ata_reg_decode
    import ata_devif_pkg::*;
(
    input  logic              cs0_n,
    input  logic              cs1_n,
    input  logic [ADDR_W-1:0] addr,
    output regsel_e           sel
);

    always_comb begin
        sel = SEL_NONE;
        if (!cs0_n && cs1_n) begin
            case (addr)
                3'd0:    sel = SEL_DATA;
                3'd1:    sel = SEL_ERRFEAT;
                3'd2:    sel = SEL_COUNT;
                3'd3:    sel = SEL_LBA0;
                3'd4:    sel = SEL_LBA1;
                3'd5:    sel = SEL_LBA2;
                3'd6:    sel = SEL_DEVICE;
                default: sel = SEL_STATCMD;
            endcase
        end else if (cs0_n && !cs1_n && addr == 3'd6) begin
            sel = SEL_ALTCTL;
        end
    end

endmodule

// File: rtl/ata_irq_ctrl.sv
module ata_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic srst_i,
    output logic pend_o
);

    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (srst_i) begin
            pend_d = 1'b0;
        end else if (set_i) begin
            pend_d = 1'b1;           // a new request beats a same-cycle clear
        end else if (clr_i) begin
            pend_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !pend_o)
        else $error("p_clear_r6");

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !srst_i) |=> pend_o)
        else $error("p_set_wins_r9");

    p_srst_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> !pend_o)
        else $error("p_srst_clears_r11");

endmodule

// File: rtl/ata_pio_devif.sv
module ata_pio_devif
    import ata_devif_pkg::*;
#(
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_slave,
    input  logic              hst_cs0_n,
    input  logic              hst_cs1_n,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic              hst_rd_n,
    input  logic              hst_wr_n,
    input  logic [DW-1:0]     hst_data_i,
    output logic [DW-1:0]     hst_data_o,
    output logic              hst_data_oe,
    output logic              hst_rdy,
    output logic              hst_w16_n,
    output logic              hst_irq,
    output logic              hst_irq_oe,
    input  logic [BYTE_W-1:0] core_stat,
    input  logic [BYTE_W-1:0] core_err,
    input  logic              core_irq_set,
    output logic              cmd_stb,
    output logic [BYTE_W-1:0] cmd_code,
    output logic [47:0]       tf_regs,
    input  logic [DW-1:0]     dp_rd_word,
    input  logic              dp_rd_avail,
    output logic              dp_rd_take,
    output logic [DW-1:0]     dp_wr_word,
    output logic              dp_wr_stb,
    input  logic              dp_wr_room
);

    localparam int SYNC_W = 4 + ADDR_W + DW;
    localparam logic [SYNC_W-1:0] SYNC_RST = {4'hF, {ADDR_W{1'b0}}, {DW{1'b0}}};

    typedef struct packed {
        taskfile_t         tf;
        logic              nien;
        logic              srst;
        logic              prev_rd_n;
        logic              prev_wr_n;
        logic [DW-1:0]     wdat;
        logic [DW-1:0]     rdat;
        logic              oe;
        logic              rdy;
        logic              w16_n;
        logic              cmd_stb;
        logic [BYTE_W-1:0] cmd;
        logic              dp_wr_stb;
        logic [DW-1:0]     dp_wr_word;
        logic              dp_rd_take;
    } state_t;

    state_t st_d, st_q;

    // ---- synchronised host pins; data rides the same delay line ----
    logic [SYNC_W-1:0] s_vec;
    logic              s_rd_n, s_wr_n, s_cs1_n, s_cs0_n;
    logic [ADDR_W-1:0] s_addr;
    logic [DW-1:0]     s_data;

    ata_sync_chain #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({hst_rd_n, hst_wr_n, hst_cs1_n, hst_cs0_n, hst_addr, hst_data_i}),
        .sync_o  (s_vec)
    );

    assign {s_rd_n, s_wr_n, s_cs1_n, s_cs0_n, s_addr, s_data} = s_vec;

    regsel_e sel;

    ata_reg_decode u_dec (
        .cs0_n (s_cs0_n),
        .cs1_n (s_cs1_n),
        .addr  (s_addr),
        .sel   (sel)
    );

    function automatic logic [DW-1:0] zx(input logic [BYTE_W-1:0] b);
        return {{(DW-BYTE_W){1'b0}}, b};
    endfunction

    logic              rd_rise, wr_rise, dev_match, dp_hit, stat_clr, irq_pend;
    logic [BYTE_W-1:0] stat_byte;
    logic [DW-1:0]     rd_mux;

    always_comb begin
        rd_rise   = s_rd_n && !st_q.prev_rd_n;
        wr_rise   = s_wr_n && !st_q.prev_wr_n;
        dev_match = (st_q.tf.device[DEV_BIT] == cfg_slave);
        dp_hit    = (sel == SEL_DATA) && dev_match;
        stat_byte = core_stat;
        if (st_q.srst) stat_byte[BSY_BIT] = 1'b1;
        stat_clr  = (sel == SEL_STATCMD) && dev_match && (rd_rise || wr_rise);

        case (sel)
            SEL_DATA:    rd_mux = dp_rd_word;
            SEL_ERRFEAT: rd_mux = zx(core_err);
            SEL_COUNT:   rd_mux = zx(st_q.tf.count);
            SEL_LBA0:    rd_mux = zx(st_q.tf.lba0);
            SEL_LBA1:    rd_mux = zx(st_q.tf.lba1);
            SEL_LBA2:    rd_mux = zx(st_q.tf.lba2);
            SEL_DEVICE:  rd_mux = zx(st_q.tf.device);
            SEL_STATCMD,
            SEL_ALTCTL:  rd_mux = zx(stat_byte);
            default:     rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d            = st_q;
        st_d.cmd_stb    = 1'b0;
        st_d.dp_wr_stb  = 1'b0;
        st_d.dp_rd_take = 1'b0;
        st_d.prev_rd_n  = s_rd_n;
        st_d.prev_wr_n  = s_wr_n;

        if (!s_wr_n) st_d.wdat = s_data;

        st_d.oe    = !s_rd_n && (sel != SEL_NONE) && dev_match;
        st_d.rdat  = st_d.oe ? rd_mux : '0;
        st_d.w16_n = !(dp_hit && (!s_rd_n || !s_wr_n));
        st_d.rdy   = !(dp_hit && ((!s_rd_n && !dp_rd_avail) ||
                                  (!s_wr_n && !dp_wr_room)));

        if (rd_rise && dp_hit) st_d.dp_rd_take = 1'b1;

        if (wr_rise) begin
            case (sel)
                SEL_ERRFEAT: st_d.tf.feat   = st_q.wdat[BYTE_W-1:0];
                SEL_COUNT:   st_d.tf.count  = st_q.wdat[BYTE_W-1:0];
                SEL_LBA0:    st_d.tf.lba0   = st_q.wdat[BYTE_W-1:0];
                SEL_LBA1:    st_d.tf.lba1   = st_q.wdat[BYTE_W-1:0];
                SEL_LBA2:    st_d.tf.lba2   = st_q.wdat[BYTE_W-1:0];
                SEL_DEVICE:  st_d.tf.device = st_q.wdat[BYTE_W-1:0];
                SEL_STATCMD: begin
                    if (dev_match) begin
                        st_d.cmd_stb = 1'b1;
                        st_d.cmd     = st_q.wdat[BYTE_W-1:0];
                    end
                end
                SEL_ALTCTL: begin
                    st_d.nien = st_q.wdat[NIEN_BIT];
                    st_d.srst = st_q.wdat[SRST_BIT];
                end
                SEL_DATA: begin
                    if (dev_match) begin
                        st_d.dp_wr_stb  = 1'b1;
                        st_d.dp_wr_word = st_q.wdat;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.prev_rd_n <= 1'b1;
            st_q.prev_wr_n <= 1'b1;
            st_q.rdy       <= 1'b1;
            st_q.w16_n     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    ata_irq_ctrl u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (core_irq_set),
        .clr_i  (stat_clr),
        .srst_i (st_q.srst),
        .pend_o (irq_pend)
    );

    assign hst_data_o  = st_q.rdat;
    assign hst_data_oe = st_q.oe;
    assign hst_rdy     = st_q.rdy;
    assign hst_w16_n   = st_q.w16_n;
    assign hst_irq     = irq_pend;
    assign hst_irq_oe  = !st_q.nien;
    assign cmd_stb     = st_q.cmd_stb;
    assign cmd_code    = st_q.cmd;
    assign tf_regs     = st_q.tf;
    assign dp_rd_take  = st_q.dp_rd_take;
    assign dp_wr_stb   = st_q.dp_wr_stb;
    assign dp_wr_word  = st_q.dp_wr_word;

    // ---- assertions ----
    p_tf_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_rise |=> $stable(st_q.tf))
        else $error("p_tf_hold_r2");

    p_oe_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rise |=> !hst_data_oe)
        else $error("p_oe_drops_r3");

    p_rdy_dp_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !hst_rdy |-> !hst_w16_n)
        else $error("p_rdy_dp_only_r4");

    p_reg_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_data_oe && hst_w16_n) |-> (hst_data_o[DW-1:BYTE_W] == '0))
        else $error("p_reg_upper_zero_r5");

    p_cmd_needs_match_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> $past(st_q.tf.device[DEV_BIT] == cfg_slave))
        else $error("p_cmd_needs_match_r12");

endmodule

// File: tb/test_ata_pio_devif.sv
module test_ata_pio_devif;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;
    localparam logic [7:0] STAT = 8'h50;
    localparam logic [7:0] ERRV = 8'h5A;

    // vector: {wr nibble, cs1-select nibble, addr byte, data/expected 16 bits}
    localparam logic [31:0] VEC [NVEC] = '{
        32'h1002_0012, 32'h1003_0034, 32'h1004_0056, 32'h1005_0078,
        32'h1001_00C3, 32'h1006_00E0, 32'h0002_0012, 32'h0003_0034,
        32'h0004_0056, 32'h0005_0078, 32'h0006_00E0, 32'h0001_005A,
        32'h0106_0050, 32'h0007_0050, 32'h1002_AB21, 32'h0002_0021
    };

    logic        clk = 1'b0, rst_n = 1'b0, cfg_slave = 1'b0;
    logic        hst_cs0_n = 1'b1, hst_cs1_n = 1'b1, hst_rd_n = 1'b1, hst_wr_n = 1'b1;
    logic [2:0]  hst_addr = '0;
    logic [15:0] hst_data_i = '0, hst_data_o, dp_rd_word = 16'hC0DE, dp_wr_word;
    logic        hst_data_oe, hst_rdy, hst_w16_n, hst_irq, hst_irq_oe;
    logic        core_irq_set = 1'b0, cmd_stb, dp_rd_take, dp_wr_stb;
    logic        dp_rd_avail = 1'b1, dp_wr_room = 1'b1;
    logic [7:0]  core_stat = STAT, core_err = ERRV, cmd_code;
    logic [47:0] tf_regs;

    int n_chk = 0, n_bad = 0;
    int cmd_cnt = 0, take_cnt = 0, wstb_cnt = 0;
    logic [7:0]  last_cmd = '0;
    logic [15:0] last_word = '0;
    logic [15:0] rd_seen;
    logic        oe_seen, w16_seen, rdy_seen;
    logic [31:0] v;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_pio_devif i_ata_pio_devif (
        .clk(clk), .rst_n(rst_n), .cfg_slave(cfg_slave),
        .hst_cs0_n(hst_cs0_n), .hst_cs1_n(hst_cs1_n), .hst_addr(hst_addr),
        .hst_rd_n(hst_rd_n), .hst_wr_n(hst_wr_n), .hst_data_i(hst_data_i),
        .hst_data_o(hst_data_o), .hst_data_oe(hst_data_oe), .hst_rdy(hst_rdy),
        .hst_w16_n(hst_w16_n), .hst_irq(hst_irq), .hst_irq_oe(hst_irq_oe),
        .core_stat(core_stat), .core_err(core_err), .core_irq_set(core_irq_set),
        .cmd_stb(cmd_stb), .cmd_code(cmd_code), .tf_regs(tf_regs),
        .dp_rd_word(dp_rd_word), .dp_rd_avail(dp_rd_avail), .dp_rd_take(dp_rd_take),
        .dp_wr_word(dp_wr_word), .dp_wr_stb(dp_wr_stb), .dp_wr_room(dp_wr_room)
    );

    // pulse monitors, sampled mid-cycle
    always @(negedge clk) begin
        if (cmd_stb)    begin cmd_cnt++;  last_cmd  = cmd_code;   end
        if (dp_rd_take) take_cnt++;
        if (dp_wr_stb)  begin wstb_cnt++; last_word = dp_wr_word; end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic alt, input logic [2:0] a,
                          input logic [15:0] wd, input logic drop_early);
        @(negedge clk);
        hst_cs0_n = alt; hst_cs1_n = !alt; hst_addr = a;
        if (wr) hst_data_i = wd;
        repeat (3) @(negedge clk);
        if (wr) hst_wr_n = 1'b0; else hst_rd_n = 1'b0;
        repeat (6) @(negedge clk);
        rd_seen = hst_data_o; oe_seen = hst_data_oe;
        w16_seen = hst_w16_n; rdy_seen = hst_rdy;
        hst_rd_n = 1'b1; hst_wr_n = 1'b1;
        if (!drop_early) begin
            repeat (6) @(negedge clk);
            hst_cs0_n = 1'b1; hst_cs1_n = 1'b1;
        end
    endtask

    task automatic pulse_irq();
        @(negedge clk); core_irq_set = 1'b1;
        @(negedge clk); core_irq_set = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // reset state
        check("reset oe",     {31'b0, hst_data_oe}, 32'd0);
        check("reset rdy R4", {31'b0, hst_rdy},     32'd1);
        check("reset w16 R5", {31'b0, hst_w16_n},   32'd1);
        check("reset irq R6", {31'b0, hst_irq},     32'd0);
        check("reset irqoe R10", {31'b0, hst_irq_oe}, 32'd1);

        // table walk: R1 R2 R5 R7
        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            access(v[28], v[24], v[18:16], v[15:0], 1'b0);
            if (!v[28]) begin
                check($sformatf("R1 vector %0d data", i), {16'h0, rd_seen}, {16'h0, v[15:0]});
                check($sformatf("R5 vector %0d width", i), {31'b0, w16_seen}, 32'd1);
            end
        end
        check("R2 task file bytes", tf_regs, 48'hE0_78_56_34_21_C3);
        repeat (3) @(negedge clk);
        check("R3 oe released", {31'b0, hst_data_oe}, 32'd0);

        // data port read and write
        access(1'b0, 1'b0, 3'd0, 16'h0, 1'b0);
        check("R5 dp read word", {16'h0, rd_seen}, 32'h0000C0DE);
        check("R5 dp width low", {31'b0, w16_seen}, 32'd0);
        check("R13 take pulse", take_cnt, 1);
        access(1'b1, 1'b0, 3'd0, 16'hBEEF, 1'b0);
        check("R13 write strobe count", wstb_cnt, 1);
        check("R13 write word", {16'h0, last_word}, 32'h0000BEEF);

        // stretched read
        dp_rd_avail = 1'b0;
        @(negedge clk); hst_cs0_n = 1'b0; hst_cs1_n = 1'b1; hst_addr = 3'd0;
        repeat (3) @(negedge clk); hst_rd_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R4 read stall rdy", {31'b0, hst_rdy}, 32'd0);
        dp_rd_avail = 1'b1; dp_rd_word = 16'h1357;
        repeat (4) @(negedge clk);
        check("R4 read resume rdy", {31'b0, hst_rdy}, 32'd1);
        check("R5 resumed word", {16'h0, hst_data_o}, 32'h00001357);
        hst_rd_n = 1'b1;
        repeat (6) @(negedge clk); hst_cs0_n = 1'b1;
        check("R13 second take", take_cnt, 2);

        // stretched write
        dp_wr_room = 1'b0;
        @(negedge clk); hst_cs0_n = 1'b0; hst_addr = 3'd0; hst_data_i = 16'h2468;
        repeat (3) @(negedge clk); hst_wr_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R4 write stall rdy", {31'b0, hst_rdy}, 32'd0);
        dp_wr_room = 1'b1;
        repeat (4) @(negedge clk);
        check("R4 write resume rdy", {31'b0, hst_rdy}, 32'd1);
        hst_wr_n = 1'b1;
        repeat (6) @(negedge clk); hst_cs0_n = 1'b1;
        check("R13 stalled write word", {16'h0, last_word}, 32'h00002468);

        // interrupt flows
        pulse_irq();
        check("R6 irq set", {31'b0, hst_irq}, 32'd1);
        access(1'b0, 1'b1, 3'd6, 16'h0, 1'b0);
        check("R7 alt status value", {16'h0, rd_seen}, {24'h0, STAT});
        check("R7 irq kept", {31'b0, hst_irq}, 32'd1);
        access(1'b0, 1'b0, 3'd7, 16'h0, 1'b0);
        check("R6 status value", {16'h0, rd_seen}, {24'h0, STAT});
        check("R6 irq cleared", {31'b0, hst_irq}, 32'd0);
        pulse_irq();
        access(1'b1, 1'b0, 3'd7, 16'h0020, 1'b0);
        check("R8 irq cleared", {31'b0, hst_irq}, 32'd0);
        check("R8 command count", cmd_cnt, 1);
        check("R8 command code", {24'h0, last_cmd}, 32'h20);

        // same-cycle set and clear
        access(1'b0, 1'b0, 3'd7, 16'h0, 1'b1);
        @(posedge clk); @(posedge clk);
        @(negedge clk); core_irq_set = 1'b1;
        @(negedge clk); core_irq_set = 1'b0;
        @(negedge clk);
        check("R9 set beats clear", {31'b0, hst_irq}, 32'd1);
        repeat (4) @(negedge clk); hst_cs0_n = 1'b1;
        access(1'b0, 1'b0, 3'd7, 16'h0, 1'b0);
        check("R9 later clear", {31'b0, hst_irq}, 32'd0);

        // interrupt disable
        access(1'b1, 1'b1, 3'd6, 16'h0002, 1'b0);
        check("R10 irq oe off", {31'b0, hst_irq_oe}, 32'd0);
        access(1'b1, 1'b1, 3'd6, 16'h0000, 1'b0);
        check("R10 irq oe on", {31'b0, hst_irq_oe}, 32'd1);

        // software reset
        pulse_irq();
        access(1'b1, 1'b1, 3'd6, 16'h0004, 1'b0);
        check("R11 srst clears irq", {31'b0, hst_irq}, 32'd0);
        pulse_irq();
        check("R11 set blocked", {31'b0, hst_irq}, 32'd0);
        access(1'b0, 1'b1, 3'd6, 16'h0, 1'b0);
        check("R11 busy forced", {16'h0, rd_seen}, {24'h0, STAT | 8'h80});
        access(1'b1, 1'b1, 3'd6, 16'h0000, 1'b0);
        access(1'b0, 1'b0, 3'd7, 16'h0, 1'b0);
        check("R11 busy released", {16'h0, rd_seen}, {24'h0, STAT});

        // device selection
        access(1'b1, 1'b0, 3'd6, 16'h00F0, 1'b0);
        access(1'b0, 1'b0, 3'd7, 16'h0, 1'b0);
        check("R12 no drive on mismatch", {31'b0, oe_seen}, 32'd0);
        access(1'b1, 1'b0, 3'd7, 16'h00EC, 1'b0);
        check("R12 command dropped", cmd_cnt, 1);
        access(1'b1, 1'b0, 3'd0, 16'h7777, 1'b0);
        check("R12 data write dropped", wstb_cnt, 2);
        cfg_slave = 1'b1;
        access(1'b0, 1'b0, 3'd6, 16'h0, 1'b0);
        check("R12 slave reads device", {16'h0, rd_seen}, 32'h000000F0);
        cfg_slave = 1'b0;
        access(1'b1, 1'b0, 3'd6, 16'h00E0, 1'b0);
        access(1'b0, 1'b0, 3'd6, 16'h0, 1'b0);
        check("R12 write taken while deselected", {16'h0, rd_seen}, 32'h000000E0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule